// File: doc/BRIEF.md
# Dilated Router Output Port Allocator

This block makes the per-stage routing decision in a circuit-switched router stage. The stage has eight message inputs, four logical directions and two physical output ports for each direction. Each input that raises a request presents a two-bit direction field taken from the message header. The allocator picks a physical port in that direction and holds it for that input until the input drops its request. When both ports of the direction are candidates, the allocator first takes only ports that are free and enabled. Among those it prefers a port whose downstream router is not blocked. A random bit from a free-running LFSR settles any remaining tie.

The allocator also produces the stage's own blocked flag for the upstream neighbour. The flag is raised when some direction has no port that is free, enabled and leads to an unblocked router. A split input turns the stage into two independent four-input routers. Inputs 0 to 3 then use the lower port of each direction and inputs 4 to 7 the upper one, and each half gets its own blocked flag.

Top module: `dil_port_alloc`

## Requirements
- R1: While reset is held, and after it, until a request is granted, `grant_o`, `busy_o` and `conn_port_o` read zero. The LFSR starts from the SEED parameter (default 16'hACE1). It first steps on the third rising edge after `rst_n` is released, because the release passes through a two-flop synchroniser. Requests are sampled from that same edge onward.
- R2: Input i's direction d is `dir_i[2i+1:2i]`. In full mode (`split_i`=0) the port granted to it is 2d or 2d+1. `conn_port_o[3i+2:3i]` shows the port while `grant_o[i]` is high and reads zero otherwise. A request sampled at a rising edge is answered in the registers updated at that edge.
- R3: A port owned by a live connection is never granted to a second input. If one port of the requested direction is in use, the other is granted, provided it is enabled.
- R4: In full mode, when both ports of the direction are free and enabled and exactly one has `dn_blocked_i` set, the port without it is granted.
- R5: When both ports are free and enabled and their `dn_blocked_i` bits are equal, bit 0 of the LFSR picks the port: 0 picks 2d and 1 picks 2d+1. The LFSR is a 16-bit Fibonacci register that shifts left each cycle. Its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R6: A port with `port_dis_i` set is never granted.
- R7: A request with no free, enabled port in its direction forms no circuit. Instead `busy_o[i]` is high for the cycle after that edge. The request is retried at every edge while it stays raised.
- R8: While `req_i[i]` stays high, the connection keeps its port, and changes on `dir_i`, `dn_blocked_i` or `port_dis_i` have no effect on it.
- R9: Dropping `req_i[i]` clears `grant_o[i]` at the next edge. The freed port can be granted from the edge after that, but not at the edge that releases it.
- R10: When several inputs request in the same cycle, they are served in ascending input index. Each takes the choice left after the lower inputs have been served.
- R11: In split mode (`split_i`=1), input i requesting direction d may only get port 2d + (i >= 4 ? 1 : 0). If that port is in use or disabled, the request is refused with busy.
- R12: In full mode, both bits of `blocked_o` are high exactly when some direction d has neither port 2d nor port 2d+1 free, enabled and with `dn_blocked_i` low. The flag is combinational from the current state and inputs.
- R13: In split mode, `blocked_o[h]` is high exactly when some direction d has port 2d+h in use, disabled or downstream-blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| split_i | input | 1 | 1 = two independent 4-input routers with one port per direction |
| req_i | input | 8 | Per-input request; held high for the life of the circuit |
| dir_i | input | 16 | Per-input two-bit direction field, input i at [2i+1:2i] |
| port_dis_i | input | 8 | Per-port disable mask (non-operational ports) |
| dn_blocked_i | input | 8 | Per-port blocked flag of the downstream router |
| grant_o | output | 8 | Per-input circuit established |
| busy_o | output | 8 | Per-input pulse: request refused at the last edge |
| conn_port_o | output | 24 | Per-input granted port index, input i at [3i+2:3i] |
| blocked_o | output | 2 | Blocked flag to upstream; one per half in split mode |

## Verification
The bench builds the block with its default geometry of eight inputs, four directions and two ports per direction, and seed 16'hACE1. With only eight ports, directed bursts can fill a whole direction, collide several inputs in one cycle and disable every port of a direction. A long random phase in each mode then keeps ports churning between use, release, disable and downstream-blocked. A behavioural model predicts every output on every cycle. That model also steps its own copy of the LFSR, so each random tie-break is predicted exactly.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  // Two physical ports per logical direction; the port-pick logic is written for this.
  localparam int DIL = 2;
  localparam int LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/alloc_lfsr.sv
module alloc_lfsr
  import alloc_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  output logic rnd_o
);
  logic [LFSR_W-1:0] st_q, st_n;
  logic              st_en;

  assign st_en = 1'b1;
  always_comb st_n = lfsr_next(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= SEED;
    else if (st_en) st_q <= st_n;
  end

  assign rnd_o = st_q[0];

  // R5: a nonzero register never locks up at zero
  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/alloc_blocked.sv
module alloc_blocked
  import alloc_pkg::*;
#(
  parameter int N_DIR = 4,
  localparam int N_OUT = N_DIR * DIL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_i,
  input  logic [N_OUT-1:0] used_i,
  input  logic [N_OUT-1:0] dis_i,
  input  logic [N_OUT-1:0] dnb_i,
  output logic [DIL-1:0]   blocked_o
);
  always_comb begin
    logic [N_OUT-1:0] good;
    logic             full_any;
    logic [DIL-1:0]   half_any;
    good     = ~used_i & ~dis_i & ~dnb_i;
    full_any = 1'b0;
    half_any = '0;
    for (int d = 0; d < N_DIR; d++) begin
      if (!(|good[d*DIL +: DIL])) full_any = 1'b1;
      for (int h = 0; h < DIL; h++)
        if (!good[d*DIL + h]) half_any[h] = 1'b1;
    end
    blocked_o = split_i ? half_any : {DIL{full_any}};
  end

  // R12: every port disabled means no usable path anywhere
  p_all_dis_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis_i) |-> (&blocked_o));
  // R13: an idle, fully healthy stage is never blocked
  p_idle_free_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (used_i == '0 && dis_i == '0 && dnb_i == '0) |-> (blocked_o == '0));
endmodule

// File: rtl/alloc_core.sv
module alloc_core
  import alloc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_DIR = 4,
  localparam int HDR_W = $clog2(N_DIR),
  localparam int N_OUT = N_DIR * DIL,
  localparam int PW    = $clog2(N_OUT),
  localparam int HALF  = N_IN / DIL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  split_i,
  input  logic [N_IN-1:0]       req_i,
  input  logic [N_IN*HDR_W-1:0] dir_i,
  input  logic [N_OUT-1:0]      dis_i,
  input  logic [N_OUT-1:0]      dnb_i,
  input  logic                  rnd_i,
  output logic [N_OUT-1:0]      used_o,
  output logic [N_IN-1:0]       grant_o,
  output logic [N_IN-1:0]       busy_o,
  output logic [N_IN*PW-1:0]    conn_port_o
);
  logic [N_IN-1:0]          cv_q, cv_n, busy_q, busy_n, ld;
  logic [N_IN-1:0][PW-1:0]  cp_q, cp_n;
  logic [N_OUT-1:0]         used;

  // Next-state: release, then fixed-priority allocation over a running taken mask
  always_comb begin
    logic [N_OUT-1:0] taken;
    logic [HDR_W-1:0] d;
    logic [PW-1:0]    pa, pb, pick;
    logic             ok_a, ok_b, hit;
    used = '0;
    for (int i = 0; i < N_IN; i++)
      if (cv_q[i]) used[cp_q[i]] = 1'b1;
    taken  = used;
    cv_n   = cv_q;
    cp_n   = cp_q;
    busy_n = '0;
    ld     = '0;
    d = '0; pa = '0; pb = '0; pick = '0; ok_a = 1'b0; ok_b = 1'b0; hit = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (cv_q[i]) begin
        if (!req_i[i]) cv_n[i] = 1'b0;
      end else if (req_i[i]) begin
        d  = dir_i[i*HDR_W +: HDR_W];
        pa = PW'(d) * PW'(DIL);
        pb = pa + PW'(1);
        if (split_i) begin
          pick = pa + PW'(i / HALF);
          hit  = !taken[pick] && !dis_i[pick];
        end else begin
          ok_a = !taken[pa] && !dis_i[pa];
          ok_b = !taken[pb] && !dis_i[pb];
          hit  = ok_a || ok_b;
          if (ok_a && ok_b) begin
            if (dnb_i[pa] != dnb_i[pb]) pick = dnb_i[pa] ? pb : pa;
            else                        pick = rnd_i ? pb : pa;
          end else begin
            pick = ok_a ? pa : pb;
          end
        end
        if (hit) begin
          cv_n[i]     = 1'b1;
          cp_n[i]     = pick;
          ld[i]       = 1'b1;
          taken[pick] = 1'b1;
        end else begin
          busy_n[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q   <= '0;
      busy_q <= '0;
      cp_q   <= '0;
    end else begin
      cv_q   <= cv_n;
      busy_q <= busy_n;
      for (int i = 0; i < N_IN; i++)
        if (ld[i]) cp_q[i] <= cp_n[i];
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++)
      conn_port_o[i*PW +: PW] = cv_q[i] ? cp_q[i] : '0;
  end

  assign used_o  = used;
  assign grant_o = cv_q;
  assign busy_o  = busy_q;

  // Ownership matrix for the one-owner checks
  logic [N_OUT-1:0][N_IN-1:0] own;
  always_comb begin
    for (int p = 0; p < N_OUT; p++)
      for (int i = 0; i < N_IN; i++)
        own[p][i] = cv_q[i] && (cp_q[i] == PW'(p));
  end

  for (genvar p = 0; p < N_OUT; p++) begin : g_port_chk
    p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own[p]) <= 1);
    p_dis_stays_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_i[p] && !used[p]) |=> !used[p]);
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_in_chk
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_q[g] && req_i[g]) |=> (cv_q[g] && $stable(cp_q[g])));
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_q[g] && !req_i[g]) |=> !cv_q[g]);
    p_busy_nocirc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[g] |-> !cv_q[g]);
    p_split_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cv_q[g]) && $past(split_i)) |-> (cp_q[g][0] == ((g >= HALF) ? 1'b1 : 1'b0)));
  end
endmodule

// File: rtl/dil_port_alloc.sv
module dil_port_alloc
  import alloc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_DIR = 4,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int HDR_W = $clog2(N_DIR),
  localparam int N_OUT = N_DIR * DIL,
  localparam int PW    = $clog2(N_OUT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  split_i,
  input  logic [N_IN-1:0]       req_i,
  input  logic [N_IN*HDR_W-1:0] dir_i,
  input  logic [N_OUT-1:0]      port_dis_i,
  input  logic [N_OUT-1:0]      dn_blocked_i,
  output logic [N_IN-1:0]       grant_o,
  output logic [N_IN-1:0]       busy_o,
  output logic [N_IN*PW-1:0]    conn_port_o,
  output logic [DIL-1:0]        blocked_o
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             rnd;
  logic [N_OUT-1:0] used;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  alloc_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_int_n), .rnd_o(rnd)
  );

  alloc_core #(.N_IN(N_IN), .N_DIR(N_DIR)) u_core (
    .clk(clk), .rst_n(rst_int_n), .split_i(split_i), .req_i(req_i),
    .dir_i(dir_i), .dis_i(port_dis_i), .dnb_i(dn_blocked_i), .rnd_i(rnd),
    .used_o(used), .grant_o(grant_o), .busy_o(busy_o), .conn_port_o(conn_port_o)
  );

  alloc_blocked #(.N_DIR(N_DIR)) u_blk (
    .clk(clk), .rst_n(rst_int_n), .split_i(split_i), .used_i(used),
    .dis_i(port_dis_i), .dnb_i(dn_blocked_i), .blocked_o(blocked_o)
  );
endmodule

// File: tb/dil_port_alloc_tb.sv
`timescale 1ns/1ps
module dil_port_alloc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        split;
  logic [7:0]  req, dis, dnb;
  logic [15:0] dir;
  logic [7:0]  grant, busy;
  logic [23:0] conn_port;
  logic [1:0]  blocked;

  always #10 clk = ~clk;

  dil_port_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .split_i(split), .req_i(req), .dir_i(dir),
    .port_dis_i(dis), .dn_blocked_i(dnb), .grant_o(grant), .busy_o(busy),
    .conn_port_o(conn_port), .blocked_o(blocked)
  );

  bit        m_cv[8];
  int        m_cp[8];
  bit        m_busy[8];
  bit [15:0] m_lfsr;
  int        vecs = 0, errs = 0;
  bit        done = 0;
  string     tag = "R1";

  task automatic check(string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit port_used(int p);
    for (int i = 0; i < 8; i++) if (m_cv[i] && m_cp[i] == p) return 1;
    return 0;
  endfunction

  function automatic bit [1:0] exp_blocked();
    bit [1:0] r = 0;
    for (int d = 0; d < 4; d++) begin
      int n = 0;
      for (int k = 0; k < 2; k++) begin
        int p = 2*d + k;
        bit ok = !port_used(p) && !dis[p] && !dnb[p];
        if (ok) n++;
        else if (split) r[k] = 1;
      end
      if (!split && n == 0) r = 2'b11;
    end
    return r;
  endfunction

  task automatic model_edge();
    bit n_cv[8]; int n_cp[8]; bit tk[8];
    for (int p = 0; p < 8; p++) tk[p] = port_used(p);
    for (int i = 0; i < 8; i++) begin
      n_cv[i] = m_cv[i]; n_cp[i] = m_cp[i]; m_busy[i] = 0;
      if (m_cv[i]) begin
        if (!req[i]) n_cv[i] = 0;
      end else if (req[i]) begin
        int d = dir[2*i +: 2];
        int got = -1;
        if (split) begin
          int p = 2*d + (i >= 4 ? 1 : 0);
          if (!tk[p] && !dis[p]) got = p;
        end else begin
          bit a = !tk[2*d] && !dis[2*d];
          bit b = !tk[2*d+1] && !dis[2*d+1];
          if (a && b) begin
            if (dnb[2*d] && !dnb[2*d+1]) got = 2*d+1;
            else if (!dnb[2*d] && dnb[2*d+1]) got = 2*d;
            else got = 2*d + int'(m_lfsr[0]);
          end else if (a) got = 2*d;
          else if (b) got = 2*d+1;
        end
        if (got >= 0) begin n_cv[i] = 1; n_cp[i] = got; tk[got] = 1; end
        else m_busy[i] = 1;
      end
    end
    for (int i = 0; i < 8; i++) begin m_cv[i] = n_cv[i]; m_cp[i] = n_cp[i]; end
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  task automatic check_regs();
    for (int i = 0; i < 8; i++) begin
      check($sformatf("grant[%0d]", i), int'(grant[i]), int'(m_cv[i]));
      check($sformatf("busy[%0d]", i), int'(busy[i]), int'(m_busy[i]));
      check($sformatf("port[%0d]", i), int'(conn_port[3*i +: 3]), m_cv[i] ? m_cp[i] : 0);
    end
  endtask

  // One cycle: inputs set at the preceding falling edge
  task automatic step();
    #1;
    check("blocked", int'(blocked), int'(exp_blocked()));
    model_edge();
    @(negedge clk);
    check_regs();
  endtask

  task automatic setdir(int i, int d);
    dir[2*i +: 2] = 2'(d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 0; split = 0; req = 0; dir = 0; dis = 0; dnb = 0;
    for (int i = 0; i < 8; i++) begin m_cv[i] = 0; m_cp[i] = 0; m_busy[i] = 0; end
    m_lfsr = 16'hACE1;
    // R1: reset state
    @(negedge clk); @(negedge clk);
    tag = "R1"; check_regs(); check("blocked", int'(blocked), 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    check_regs();

    // R2: direction decode
    tag = "R2"; req[0] = 1; setdir(0, 3); req[1] = 1; setdir(1, 1); step(); step();
    req = 0; step();
    // R5: ties broken by the LFSR
    tag = "R5";
    for (int k = 0; k < 8; k++) begin
      req[0] = 1; setdir(0, k % 4); dnb = (k % 3 == 0) ? 8'hFF : 8'h00; step();
      req[0] = 0; step();
    end
    dnb = 0;
    // R4: downstream-blocked port avoided
    tag = "R4"; dnb[4] = 1; req[2] = 1; setdir(2, 2); step();
    req[2] = 0; dnb = 0; dnb[7] = 1; req[3] = 1; setdir(3, 3); step();
    req = 0; dnb = 0; step();
    // R3 / R7 / R8 / R9: fill a direction, refuse, hold, release
    tag = "R3"; req[0] = 1; setdir(0, 1); step();
    req[1] = 1; setdir(1, 1); step();
    tag = "R7"; req[2] = 1; setdir(2, 1); step(); step();
    tag = "R8"; setdir(0, 2); setdir(1, 0); dnb = 8'hFF; dis[2] = 1; step(); step();
    dnb = 0; dis = 0;
    tag = "R9"; req[0] = 0; step(); step(); step();
    req = 0; step();
    // R6: disabled ports
    tag = "R6"; dis[0] = 1; req[3] = 1; setdir(3, 0); step();
    dis[1] = 1; req[4] = 1; setdir(4, 0); step(); step();
    req = 0; step(); dis = 0;
    // R10: same-cycle priority
    tag = "R10"; req[5] = 1; req[6] = 1; req[7] = 1;
    setdir(5, 3); setdir(6, 3); setdir(7, 3); step(); step();
    req = 0; step();
    // R12: blocked flag, full mode
    tag = "R12"; dnb[2] = 1; req[0] = 1; setdir(0, 1); step(); step();
    dnb[2] = 0; step(); dis[6] = 1; dis[7] = 1; step();
    req = 0; dis = 0; dnb = 0; step();
    // R11 / R13: split mode
    split = 1; tag = "R11";
    req[1] = 1; setdir(1, 2); req[6] = 1; setdir(6, 2); step();
    req[2] = 1; setdir(2, 2); step(); step();
    tag = "R13"; dnb[1] = 1; step(); dis[3] = 1; step();
    req = 0; dis = 0; dnb = 0; step(); step();

    // Random churn, full mode then split mode
    for (int ph = 0; ph < 2; ph++) begin
      split = ph[0];
      tag = ph == 0 ? "R12" : "R13";
      for (int c = 0; c < 1500; c++) begin
        for (int i = 0; i < 8; i++) begin
          if (req[i]) begin if ($urandom_range(7) == 0) req[i] = 0; end
          else if ($urandom_range(2) == 0) req[i] = 1;
          setdir(i, int'($urandom_range(3)));
        end
        dnb = 8'($urandom) & 8'($urandom);
        if ($urandom_range(15) == 0) dis = 8'($urandom) & 8'($urandom) & 8'($urandom);
        step();
      end
      req = 0; dis = 0; dnb = 0; step(); step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule